// File: doc/BRIEF.md
# Chained Serial Output Formatter

This block turns seven parallel 16-bit result words into two serial bit streams that share one serial clock and one frame sync. The words are in-phase, quadrature, magnitude, phase, frequency, timing error and gain level. A load strobe copies all seven words into shadow storage at once. Each stream then sends words, most significant bit first, starting from its own chosen source. Each source has a programmable successor, so every stream walks its own linked list of words for a programmed number of words per frame.

Any source can be set to send a one-bit tag in front of its word. The serial clock comes from the processing clock through a programmable divider. Both the clock and the sync can be inverted. The sync can sit on the first data bit of the frame or on an extra leading slot. Configuration is written through a simple address, data and write-enable port.

Top module: `serial_chain_fmt`

## Requirements
- R1: Source codes select words as follows. Code k from 0 to 6 selects `res_words[16k+15:16k]`, where 0 is I, 1 is Q, 2 is magnitude, 3 is phase, 4 is frequency, 5 is timing error and 6 is gain. Code 7 selects a constant-zero word.
- R2: Every word goes out as 16 bits, most significant bit first, one bit per serial slot.
- R3: When the tag enable of a source is set, that source's word is preceded by one slot that carries a 1. The zero source never has a tag.
- R4: After a word from source s, the next word of the same stream comes from the source named in the link field of s. The link of the zero source is always the zero source.
- R5: Each stream sends exactly (length field + 1) words per frame. After its last bit, that stream's output is 0 until the frame ends.
- R6: Stream A and stream B each start from their own start code and advance independently of each other.
- R7: A serial slot lasts 2*(div+1) processing clocks. The internal serial clock is low for the first div+1 clocks of the slot and high for the rest. Data changes only at slot boundaries. While idle, the internal serial clock is low and both data outputs are 0.
- R8: `ser_clk` is the internal serial clock XOR the clock-invert bit. `ser_sync` is the internal sync XOR the sync-invert bit.
- R9: The internal sync is active for exactly the first slot of a frame. With the early bit clear, that slot carries the first data bit. With it set, that slot is an extra leading slot with both data outputs 0, and data starts in the next slot.
- R10: A strobe that comes while idle captures all words and starts a frame on the next clock. Input words that change after the capture have no effect on the frame.
- R11: A strobe during a frame does not disturb the frame. It sets `overrun`, which then stays set until reset.
- R12: The register map (cfg_wdata bits) is:
  - address 0: A start code in [2:0] and B start code in [5:3];
  - addresses 1 to 7: the link field of source (address-1) in [2:0];
  - address 8: tag enables in [6:0], where bit k belongs to source k;
  - address 9: length field in [2:0];
  - address 10: div in [7:0];
  - address 11: clock-invert in [0], sync-invert in [1] and early in [2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| res_words | input | 112 | Seven packed 16-bit result words |
| load_stb | input | 1 | Capture words and start a frame |
| ser_clk | output | 1 | Serial clock, polarity selectable |
| ser_sync | output | 1 | Frame sync, polarity selectable |
| ser_a | output | 1 | Serial data stream A |
| ser_b | output | 1 | Serial data stream B |
| overrun | output | 1 | Sticky flag for a strobe lost during a frame |

## Verification
Some rules are checked by assertions on every cycle: the overrun flag stays set and is set by a strobe during a frame; an idle formatter holds both streams finished and the serial clock low; the divider clears itself when stopped; the bit index stays in range; and a launched stream starts from its selected source. Only the bench scenarios can show the following: the exact bit order of linked chains with and without tags, how stream lengths line up against a shared frame, where the sync falls in early and normal modes, the effect of inversion, and that words are not affected by input changes after capture.

// File: rtl/sof_pkg.sv
package sof_pkg;
    localparam int NSRC  = 7;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SRC_ZERO = 3'd7;

    localparam int ADDR_START = 0;
    localparam int ADDR_LINK0 = 1;
    localparam int ADDR_TAG   = 8;
    localparam int ADDR_LEN   = 9;
    localparam int ADDR_DIV   = 10;
    localparam int ADDR_MODE  = 11;

    typedef struct packed {
        logic early;
        logic sync_inv;
        logic clk_inv;
    } mode_t;
endpackage

// File: rtl/sof_cfg_regs.sv
module sof_cfg_regs
    import sof_pkg::*;
#(
    parameter int CFG_AW = 4,
    parameter int CFG_DW = 16,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [CFG_AW-1:0]       addr,
    input  logic [CFG_DW-1:0]       wdata,
    output logic [SEL_W-1:0]        sel_a,
    output logic [SEL_W-1:0]        sel_b,
    output logic [NSRC*SEL_W-1:0]   links,
    output logic [NSRC-1:0]         tag_en,
    output logic [LEN_W-1:0]        frame_len,
    output logic [DIV_W-1:0]        div,
    output mode_t                   mode
);
    typedef struct packed {
        logic [SEL_W-1:0]      sel_a;
        logic [SEL_W-1:0]      sel_b;
        logic [NSRC*SEL_W-1:0] links;
        logic [NSRC-1:0]       tag;
        logic [LEN_W-1:0]      len;
        logic [DIV_W-1:0]      div;
        mode_t                 mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == CFG_AW'(ADDR_START)) begin
                cfg_d.sel_a = wdata[SEL_W-1:0];
                cfg_d.sel_b = wdata[2*SEL_W-1:SEL_W];
            end
            for (int k = 0; k < NSRC; k++) begin
                if (addr == CFG_AW'(ADDR_LINK0 + k))
                    cfg_d.links[k*SEL_W +: SEL_W] = wdata[SEL_W-1:0];
            end
            if (addr == CFG_AW'(ADDR_TAG))  cfg_d.tag  = wdata[NSRC-1:0];
            if (addr == CFG_AW'(ADDR_LEN))  cfg_d.len  = wdata[LEN_W-1:0];
            if (addr == CFG_AW'(ADDR_DIV))  cfg_d.div  = wdata[DIV_W-1:0];
            if (addr == CFG_AW'(ADDR_MODE)) cfg_d.mode = mode_t'(wdata[2:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.sel_b <= SEL_W'(1);
            cfg_q.links <= {NSRC{SRC_ZERO}};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_a     = cfg_q.sel_a;
    assign sel_b     = cfg_q.sel_b;
    assign links     = cfg_q.links;
    assign tag_en    = cfg_q.tag;
    assign frame_len = cfg_q.len;
    assign div       = cfg_q.div;
    assign mode      = cfg_q.mode;
endmodule

// File: rtl/sof_bit_timer.sv
module sof_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half,
    output logic             slot_end
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        slot_end = 1'b0;
        if (!run) begin
            tmr_d = '0;
        end else if (tmr_q.cnt == div) begin
            tmr_d.cnt  = '0;
            tmr_d.half = ~tmr_q.half;
            slot_end   = tmr_q.half;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign half = tmr_q.half;

    // R7
    timer_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tmr_q.cnt == '0 && !tmr_q.half));
endmodule

// File: rtl/sof_stream.sv
module sof_stream
    import sof_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch,
    input  logic                     advance,
    input  logic [SEL_W-1:0]         start_sel,
    input  logic [NSRC*SEL_W-1:0]    links,
    input  logic [NSRC-1:0]          tag_en,
    input  logic [LEN_W-1:0]         frame_len,
    input  logic [NSRC*WORD_W-1:0]   words,
    output logic                     sdata,
    output logic                     last,
    output logic                     done
);
    localparam int NCODE = 1 << SEL_W;
    localparam int BIT_W = $clog2(WORD_W + 1);
    localparam logic [BIT_W-1:0] TAG_POS = BIT_W'(WORD_W);
    localparam logic [BIT_W-1:0] TOP_POS = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic [BIT_W-1:0] bitp;
        logic [LEN_W-1:0] left;
        logic             done;
    } strm_t;

    strm_t st_d, st_q;

    logic [WORD_W-1:0] word_arr [NCODE];
    logic [SEL_W-1:0]  link_arr [NCODE];
    logic              tag_arr  [NCODE];

    for (genvar k = 0; k < NCODE; k++) begin : g_code
        if (k < NSRC) begin : g_src
            assign word_arr[k] = words[k*WORD_W +: WORD_W];
            assign link_arr[k] = links[k*SEL_W +: SEL_W];
            assign tag_arr[k]  = tag_en[k];
        end else begin : g_zero
            assign word_arr[k] = '0;
            assign link_arr[k] = SRC_ZERO;
            assign tag_arr[k]  = 1'b0;
        end
    end

    logic [WORD_W:0] framed;
    assign framed = {1'b1, word_arr[st_q.src]};

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.src  = start_sel;
            st_d.bitp = tag_arr[start_sel] ? TAG_POS : TOP_POS;
            st_d.left = frame_len;
            st_d.done = 1'b0;
        end else if (advance && !st_q.done) begin
            if (st_q.bitp == '0) begin
                if (st_q.left == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.src  = link_arr[st_q.src];
                    st_d.bitp = tag_arr[link_arr[st_q.src]] ? TAG_POS : TOP_POS;
                    st_d.left = st_q.left - 1'b1;
                end
            end else begin
                st_d.bitp = st_q.bitp - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata = !st_q.done && framed[st_q.bitp];
    assign last  = st_q.done || (st_q.bitp == '0 && st_q.left == '0);
    assign done  = st_q.done;

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bitp <= TAG_POS);
    // R6
    launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!st_q.done && st_q.src == $past(start_sel)));
    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !launch) |=> st_q.done);
endmodule

// File: rtl/serial_chain_fmt.sv
module serial_chain_fmt
    import sof_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 3,
    parameter int CFG_AW = 4,
    parameter int CFG_DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    input  logic [NSRC*WORD_W-1:0] res_words,
    input  logic                   load_stb,
    output logic                   ser_clk,
    output logic                   ser_sync,
    output logic                   ser_a,
    output logic                   ser_b,
    output logic                   overrun
);
    typedef struct packed {
        logic                   busy;
        logic                   first;
        logic                   pre;
        logic                   ovr;
        logic [NSRC*WORD_W-1:0] words;
    } top_t;

    top_t top_d, top_q;

    logic [SEL_W-1:0]      sel_a, sel_b;
    logic [NSRC*SEL_W-1:0] links;
    logic [NSRC-1:0]       tag_en;
    logic [LEN_W-1:0]      frame_len;
    logic [DIV_W-1:0]      div;
    mode_t                 mode;
    logic                  half, slot_end;
    logic                  launch, advance;
    logic                  a_data, a_last, a_done;
    logic                  b_data, b_last, b_done;

    sof_cfg_regs #(
        .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .DIV_W(DIV_W), .LEN_W(LEN_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .sel_a(sel_a), .sel_b(sel_b), .links(links), .tag_en(tag_en),
        .frame_len(frame_len), .div(div), .mode(mode)
    );

    sof_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(top_q.busy), .div(div),
        .half(half), .slot_end(slot_end)
    );

    sof_stream #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_strm_a (
        .clk(clk), .rst_n(rst_n), .launch(launch), .advance(advance),
        .start_sel(sel_a), .links(links), .tag_en(tag_en), .frame_len(frame_len),
        .words(top_q.words), .sdata(a_data), .last(a_last), .done(a_done)
    );

    sof_stream #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_strm_b (
        .clk(clk), .rst_n(rst_n), .launch(launch), .advance(advance),
        .start_sel(sel_b), .links(links), .tag_en(tag_en), .frame_len(frame_len),
        .words(top_q.words), .sdata(b_data), .last(b_last), .done(b_done)
    );

    always_comb begin
        top_d   = top_q;
        launch  = 1'b0;
        advance = top_q.busy && slot_end && !top_q.pre;
        if (load_stb) begin
            if (top_q.busy) begin
                top_d.ovr = 1'b1;
            end else begin
                launch      = 1'b1;
                top_d.busy  = 1'b1;
                top_d.first = 1'b1;
                top_d.pre   = mode.early;
                top_d.words = res_words;
            end
        end
        if (top_q.busy && slot_end) begin
            top_d.first = 1'b0;
            top_d.pre   = 1'b0;
            if (!top_q.pre && a_last && b_last) top_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign ser_clk  = (top_q.busy & half) ^ mode.clk_inv;
    assign ser_sync = (top_q.busy & top_q.first) ^ mode.sync_inv;
    assign ser_a    = top_q.busy && !top_q.pre && a_data;
    assign ser_b    = top_q.busy && !top_q.pre && b_data;
    assign overrun  = top_q.ovr;

    // R11
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.ovr |=> top_q.ovr);
    // R11
    busy_strobe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.busy && load_stb) |=> top_q.ovr);
    // R5
    idle_streams_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !top_q.busy |-> (a_done && b_done));
    // R7
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !top_q.busy |-> !half);
endmodule

// File: tb/serial_chain_fmt_bench.sv
module serial_chain_fmt_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [15:0]  cfg_wdata = '0;
    logic [111:0] res_words = '0;
    logic         load_stb = 1'b0;
    logic         ser_clk, ser_sync, ser_a, ser_b, overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] w [7];
    int  lk [8];
    bit  tg [8];
    int  st_a, st_b, flen, fdiv;
    bit  cinv, sinv, early;
    bit  exp_ovr;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    serial_chain_fmt u_serial_chain_fmt (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_words(res_words), .load_stb(load_stb),
        .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_a(ser_a), .ser_b(ser_b),
        .overrun(overrun)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R12: register map written as stated
    task automatic apply_cfg();
        wr(0, st_a | (st_b << 3));
        for (int k = 0; k < 7; k++) wr(1 + k, lk[k]);
        begin
            int t = 0;
            for (int k = 0; k < 7; k++) if (tg[k]) t |= (1 << k);
            wr(8, t);
        end
        wr(9, flen);
        wr(10, fdiv);
        wr(11, int'(cinv) | (int'(sinv) << 1) | (int'(early) << 2));
    endtask

    function automatic logic [15:0] src_word(input int c);
        return (c == 7) ? 16'h0 : w[c];
    endfunction

    task automatic new_words();
        for (int k = 0; k < 7; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            w[k] = seed[31:16];
        end
    endtask

    // R1 R2 R3 R4 R5: expected bits of one stream
    task automatic build(input int start, output bit bits [160], output int n);
        int s = start;
        n = 0;
        for (int i = 0; i < 160; i++) bits[i] = 1'b0;
        for (int wd = 0; wd <= flen; wd++) begin
            if (s != 7 && tg[s]) begin bits[n] = 1'b1; n++; end
            for (int b = 15; b >= 0; b--) begin bits[n] = src_word(s)[b]; n++; end
            s = (s == 7) ? 7 : lk[s];
        end
    endtask

    task automatic run_frame(input int inj);
        bit ea [160];
        bit eb [160];
        int na, nb, pre, nslots;
        build(st_a, ea, na);
        build(st_b, eb, nb);
        pre = early ? 1 : 0;
        nslots = pre + ((na > nb) ? na : nb);
        @(negedge clk);
        for (int k = 0; k < 7; k++) res_words[k*16 +: 16] = w[k];
        load_stb = 1'b1;
        @(posedge clk);
        #1;
        load_stb = 1'b0;
        res_words = ~res_words;   // R10: changes after capture must not matter
        for (int s = 0; s < nslots; s++) begin
            logic xa, xb, xs;
            int d = s - pre;
            xa = (s >= pre && d < na) ? ea[d] : 1'b0;
            xb = (s >= pre && d < nb) ? eb[d] : 1'b0;
            xs = (s == 0) ^ sinv;
            @(negedge clk);
            chk("R7 clk low half", ser_clk, cinv);
            chk("R9 sync low half", ser_sync, xs);
            chk("R2 stream A low half", ser_a, xa);
            chk("R6 stream B low half", ser_b, xb);
            if (s == inj) begin
                load_stb = 1'b1;
                @(negedge clk);
                load_stb = 1'b0;
                exp_ovr = 1'b1;
                repeat (fdiv) @(negedge clk);
            end else begin
                repeat (fdiv + 1) @(negedge clk);
            end
            chk("R8 clk high half", ser_clk, ~cinv);
            chk("R9 sync high half", ser_sync, xs);
            chk("R4 stream A high half", ser_a, xa);
            chk("R5 stream B high half", ser_b, xb);
            repeat (fdiv) @(negedge clk);
        end
        @(negedge clk);
        chk("R7 idle clock", ser_clk, cinv);
        chk("R8 idle sync", ser_sync, sinv);
        chk("R5 idle A", ser_a, 1'b0);
        chk("R5 idle B", ser_b, 1'b0);
        chk("R11 overrun flag", overrun, exp_ovr);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        exp_ovr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset clock", ser_clk, 1'b0);
        chk("R9 reset sync", ser_sync, 1'b0);
        chk("R7 reset A", ser_a, 1'b0);
        chk("R7 reset B", ser_b, 1'b0);
        chk("R11 reset overrun", overrun, 1'b0);

        // R1 R6: every start code on both streams, single word
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) begin lk[k] = 7; tg[k] = 0; end
            st_a = c; st_b = 7 - c; flen = 0; fdiv = 0;
            cinv = 0; sinv = 0; early = 0;
            new_words();
            apply_cfg();
            run_frame(-1);
        end

        // R3 R4 R5: long chains with alternating tags, B runs into zero
        for (int k = 0; k < 8; k++) begin lk[k] = (k == 7) ? 7 : k + 1; tg[k] = (k % 2 == 0); end
        lk[6] = 7;
        st_a = 0; st_b = 3; flen = 7; fdiv = 1;
        new_words();
        apply_cfg();
        run_frame(-1);

        // R4: out-of-order loop through links
        lk[0] = 4; lk[4] = 2; lk[2] = 6; lk[6] = 0; lk[1] = 5; lk[5] = 3; lk[3] = 1;
        for (int k = 0; k < 8; k++) tg[k] = (k == 2) || (k == 5);
        st_a = 0; st_b = 1; flen = 5; fdiv = 0;
        new_words();
        apply_cfg();
        run_frame(-1);

        // R7 R8 R9: divider, polarity and sync position sweep
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 8; k++) tg[k] = 1;
            cinv = m[0]; sinv = m[1]; early = m[2];
            fdiv = m % 4; flen = 1; st_a = m % 7; st_b = (m + 3) % 8;
            new_words();
            apply_cfg();
            run_frame(-1);
        end

        // R10 R11: strobe during a frame is ignored and flagged
        cinv = 0; sinv = 0; early = 1; fdiv = 2; flen = 2; st_a = 2; st_b = 5;
        new_words();
        apply_cfg();
        run_frame(3);
        run_frame(-1);   // R11: flag still set after a clean frame

        // R11: reset clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 overrun cleared by reset", overrun, 1'b0);
        chk("R8 clock polarity back to default", ser_clk, 1'b0);
        finish_run();
    end
endmodule